// File: doc/BRIEF.md
# AXI4 Write-to-Stream Bridge

This block is the slave end of an AXI4 write port whose data goes out as an AXI-Stream. It takes address handshakes on AW and data beats on W, and it sends every beat out as one stream beat. The last beat of a write burst becomes the end of a stream packet. When the final beat has left on the stream side, the bridge returns an OKAY response on B. Read channels, address decoding and error responses are not part of it. Addresses and burst lengths are not carried on the port. A burst ends at the beat that has wlast set.

Data beats pass through a two-entry registered stage. Every output of that stage comes straight from a flop, and wready depends only on registered state, so the stream's tready never has a combinational path back to the AXI4 side. One burst can be open while a second address request is accepted and held pending. Bursts can then follow each other at one beat per clock. When the stream stalls, the stall shows up as wready dropping. Because the open burst cannot finish, the address side also blocks once a request is pending. A bounded counter of unanswered bursts limits how far AW acceptance can run ahead of B.

Top module: `axi4w_to_axis`

## Requirements
- R1: After reset is released, awready is 1 and wready, tvalid and bvalid are 0. bresp always reads 2'b00 (OKAY).
- R2: An AW request is accepted when awvalid and awready are both 1 at a clock edge. awready is 0 whenever two accepted bursts have not yet received their wlast beat, that is, one burst is open and one is pending.
- R3: wready is 0 whenever no accepted AW request is waiting for its wlast beat. A W beat is never taken before its address handshake has completed on an earlier edge.
- R4: Each accepted W beat appears exactly once on the stream, in order. tdata equals wdata, tkeep equals wstrb and tlast equals wlast. A beat reaches tvalid one clock after the edge that accepted it.
- R5: While tready, awvalid and wvalid are held at 1, consecutive bursts go out at one stream beat per clock with no gap between bursts.
- R6: While tvalid is 1 and tready is 0, tvalid, tdata, tkeep and tlast hold their values. The data stage holds at most two beats, and wready is 0 while it holds two.
- R7: bvalid rises only on the clock after a beat with tlast has been transferred on the stream. bvalid then stays 1 until a cycle with bready at 1.
- R8: Each stream tlast transfer produces one B handshake. If a tlast transfer and a B handshake fall in the same cycle, the number of responses still owed is unchanged.
- R9: awready is 0 while MAX_BURSTS accepted bursts have not yet completed their B handshake.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| s_awvalid | input | 1 | Write address request valid |
| s_awready | output | 1 | Write address request accepted |
| s_wdata | input | DATA_W | Write data |
| s_wstrb | input | DATA_W/8 | Write byte strobes, passed through |
| s_wlast | input | 1 | Last beat of the burst |
| s_wvalid | input | 1 | Write data valid |
| s_wready | output | 1 | Write data accepted |
| s_bresp | output | 2 | Write response, always OKAY |
| s_bvalid | output | 1 | Write response valid |
| s_bready | input | 1 | Write response taken |
| m_tdata | output | DATA_W | Stream data |
| m_tkeep | output | DATA_W/8 | Stream byte qualifiers |
| m_tlast | output | 1 | End of stream packet |
| m_tvalid | output | 1 | Stream beat valid |
| m_tready | input | 1 | Stream sink ready |

## Verification
The bench drives both the response queue and the address tracker with two events in the same cycle. On the B side, a tlast beat leaving the stream and a B handshake land on one edge. On the address side, an AW acceptance and a wlast acceptance land on one edge. Short bursts of one or two beats, together with bready and tready toggling at random, make both coincidences frequent. Each coincidence is judged by a behavioural model that counts open bursts, unanswered bursts and owed responses. The model is compared on every clock against awready, wready and bvalid, so a miscount in either collision shows up as a wrong ready or valid level on a later cycle.

// File: rtl/axisb_pkg.sv
package axisb_pkg;
  localparam logic [1:0] RESP_OKAY = 2'b00;
  localparam int unsigned OPEN_MAX = 2;
endpackage

// File: rtl/axisb_skid.sv
module axisb_skid #(
  parameter int unsigned WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [WIDTH-1:0] in_data,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [WIDTH-1:0] out_data
);
  logic             hold_valid;
  logic [WIDTH-1:0] hold_data;
  logic             in_fire;

  assign in_ready = !hold_valid;
  assign in_fire  = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid  <= 1'b0;
      hold_valid <= 1'b0;
    end else if (!out_valid || out_ready) begin
      if (hold_valid) begin
        out_valid  <= 1'b1;
        hold_valid <= 1'b0;
      end else begin
        out_valid <= in_fire;
      end
    end else if (in_fire) begin
      hold_valid <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!out_valid || out_ready) begin
      if (hold_valid) out_data <= hold_data;
      else if (in_fire) out_data <= in_data;
    end else if (in_fire) begin
      hold_data <= in_data;
    end
  end

  // R6: the spare slot is only ever filled behind an occupied output
  p_no_overflow_r6: assert property (@(posedge clk) disable iff (rst)
    hold_valid |-> out_valid);
  // R6 / R4: a stalled output beat does not change
  p_stall_hold_r6: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));
endmodule

// File: rtl/axisb_track.sv
module axisb_track
  import axisb_pkg::*;
#(
  parameter int unsigned MAX_BURSTS = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic aw_valid,
  output logic aw_ready,
  input  logic w_last_fire,
  input  logic b_fire,
  output logic w_open
);
  localparam int unsigned CW = $clog2(MAX_BURSTS + 1);
  localparam logic [CW-1:0] TOTAL_LIM = CW'(MAX_BURSTS);

  logic [1:0]    open_cnt;
  logic [CW-1:0] total_cnt;
  logic          aw_fire;

  assign aw_ready = (open_cnt != 2'(OPEN_MAX)) && (total_cnt != TOTAL_LIM);
  assign aw_fire  = aw_valid && aw_ready;
  assign w_open   = (open_cnt != 2'd0);

  always_ff @(posedge clk) begin
    if (rst) begin
      open_cnt  <= '0;
      total_cnt <= '0;
    end else begin
      open_cnt  <= open_cnt + 2'(aw_fire) - 2'(w_last_fire);
      total_cnt <= total_cnt + CW'(aw_fire) - CW'(b_fire);
    end
  end

  // R9: every burst still open for data is also unanswered
  p_total_cover_r9: assert property (@(posedge clk) disable iff (rst)
    w_open |-> (total_cnt != '0));
  // R3: a burst end is only seen while a burst is open
  p_last_needs_aw_r3: assert property (@(posedge clk) disable iff (rst)
    w_last_fire |-> w_open);
endmodule

// File: rtl/axisb_bresp.sv
module axisb_bresp
  import axisb_pkg::*;
#(
  parameter int unsigned MAX_BURSTS = 4
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       t_last_fire,
  output logic       b_valid,
  input  logic       b_ready,
  output logic [1:0] b_resp
);
  localparam int unsigned CW = $clog2(MAX_BURSTS + 1);
  localparam logic [CW-1:0] OWED_LIM = CW'(MAX_BURSTS);

  logic [CW-1:0] owed;

  assign b_valid = (owed != '0);
  assign b_resp  = RESP_OKAY;

  always_ff @(posedge clk) begin
    if (rst) owed <= '0;
    else     owed <= owed + CW'(t_last_fire) - CW'(b_valid && b_ready);
  end

  // R8: the response queue never wraps
  p_owed_no_overflow_r8: assert property (@(posedge clk) disable iff (rst)
    t_last_fire |-> (owed != OWED_LIM));
  // R7: a pending response waits for bready
  p_b_hold_r7: assert property (@(posedge clk) disable iff (rst)
    (b_valid && !b_ready) |=> b_valid);
  // R7: a response only appears after a packet end left the stream
  p_b_after_tlast_r7: assert property (@(posedge clk) disable iff (rst)
    $rose(b_valid) |-> $past(t_last_fire));
endmodule

// File: rtl/axi4w_to_axis.sv
module axi4w_to_axis
  import axisb_pkg::*;
#(
  parameter int unsigned DATA_W     = 32,
  parameter int unsigned MAX_BURSTS = 4
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                s_awvalid,
  output logic                s_awready,
  input  logic [DATA_W-1:0]   s_wdata,
  input  logic [DATA_W/8-1:0] s_wstrb,
  input  logic                s_wlast,
  input  logic                s_wvalid,
  output logic                s_wready,
  output logic [1:0]          s_bresp,
  output logic                s_bvalid,
  input  logic                s_bready,
  output logic [DATA_W-1:0]   m_tdata,
  output logic [DATA_W/8-1:0] m_tkeep,
  output logic                m_tlast,
  output logic                m_tvalid,
  input  logic                m_tready
);
  localparam int unsigned STRB_W = DATA_W / 8;
  localparam int unsigned BEAT_W = DATA_W + STRB_W + 1;

  logic              w_open;
  logic              stage_ready;
  logic [BEAT_W-1:0] beat_in;
  logic [BEAT_W-1:0] beat_out;
  logic              w_last_fire;
  logic              t_last_fire;

  assign s_wready    = stage_ready && w_open;
  assign beat_in     = {s_wlast, s_wstrb, s_wdata};
  assign w_last_fire = s_wvalid && s_wready && s_wlast;
  assign t_last_fire = m_tvalid && m_tready && m_tlast;
  assign {m_tlast, m_tkeep, m_tdata} = beat_out;

  axisb_track #(.MAX_BURSTS(MAX_BURSTS)) u_track (
    .clk         (clk),
    .rst         (rst),
    .aw_valid    (s_awvalid),
    .aw_ready    (s_awready),
    .w_last_fire (w_last_fire),
    .b_fire      (s_bvalid && s_bready),
    .w_open      (w_open)
  );

  axisb_skid #(.WIDTH(BEAT_W)) u_stage (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (s_wvalid && w_open),
    .in_ready  (stage_ready),
    .in_data   (beat_in),
    .out_valid (m_tvalid),
    .out_ready (m_tready),
    .out_data  (beat_out)
  );

  axisb_bresp #(.MAX_BURSTS(MAX_BURSTS)) u_bresp (
    .clk         (clk),
    .rst         (rst),
    .t_last_fire (t_last_fire),
    .b_valid     (s_bvalid),
    .b_ready     (s_bready),
    .b_resp      (s_bresp)
  );

  // R4: stream packet end stays put while stalled
  p_tlast_hold_r4: assert property (@(posedge clk) disable iff (rst)
    (m_tvalid && !m_tready) |=> ($stable(m_tlast) && $stable(m_tkeep)));
endmodule

// File: tb/tb_axi4w_to_axis.sv
module tb_axi4w_to_axis;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 32;
  localparam int SW = DW / 8;
  localparam int MAXB = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic s_awvalid = 1'b0, s_awready;
  logic [DW-1:0] s_wdata = '0;
  logic [SW-1:0] s_wstrb = '0;
  logic s_wlast = 1'b0, s_wvalid = 1'b0, s_wready;
  logic [1:0] s_bresp;
  logic s_bvalid, s_bready = 1'b0;
  logic [DW-1:0] m_tdata;
  logic [SW-1:0] m_tkeep;
  logic m_tlast, m_tvalid, m_tready = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  axi4w_to_axis #(.DATA_W(DW), .MAX_BURSTS(MAXB)) dut (
    .clk(clk), .rst(rst),
    .s_awvalid(s_awvalid), .s_awready(s_awready),
    .s_wdata(s_wdata), .s_wstrb(s_wstrb), .s_wlast(s_wlast),
    .s_wvalid(s_wvalid), .s_wready(s_wready),
    .s_bresp(s_bresp), .s_bvalid(s_bvalid), .s_bready(s_bready),
    .m_tdata(m_tdata), .m_tkeep(m_tkeep), .m_tlast(m_tlast),
    .m_tvalid(m_tvalid), .m_tready(m_tready)
  );

  int checks = 0;
  int errors = 0;

  // behavioural model state
  logic [DW+SW:0] mq[$];
  int m_open = 0, m_total = 0, m_owed = 0;
  int p_aw = 50, p_w = 50, p_t = 50, p_b = 50;
  int beat_idx = 0, burst_len = 1;
  logic aw_fired = 1'b0, w_fired = 1'b0;
  int t_beats = 0, same_cycle_b = 0, aw_block_seen = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic compare();
    bit exp_awr, exp_wr, exp_tv, exp_bv;
    exp_awr = (m_open < 2) && (m_total < MAXB);
    exp_wr  = (mq.size() < 2) && (m_open != 0);
    exp_tv  = (mq.size() > 0);
    exp_bv  = (m_owed > 0);
    chk(s_awready == exp_awr, (m_total >= MAXB) ? "R9" : "R2", "awready", 64'(s_awready), 64'(exp_awr));
    chk(s_wready == exp_wr, (m_open == 0) ? "R3" : "R6", "wready", 64'(s_wready), 64'(exp_wr));
    chk(m_tvalid == exp_tv, "R4", "tvalid", 64'(m_tvalid), 64'(exp_tv));
    if (exp_tv)
      chk({m_tlast, m_tkeep, m_tdata} == mq[0], "R4", "beat", 64'({m_tlast, m_tkeep, m_tdata}), 64'(mq[0]));
    chk(s_bvalid == exp_bv, "R7", "bvalid", 64'(s_bvalid), 64'(exp_bv));
    chk(s_bresp == 2'b00, "R1", "bresp", 64'(s_bresp), 64'd0);
    if (!exp_awr && m_open == 2) aw_block_seen++;
  endtask

  task automatic drive();
    if (!s_awvalid || aw_fired) s_awvalid = ($urandom % 100) < p_aw;
    if (!s_wvalid || w_fired) begin
      if (w_fired) begin
        if (s_wlast) begin beat_idx = 0; burst_len = 1 + $urandom % 4; end
        else beat_idx++;
      end
      s_wvalid = ($urandom % 100) < p_w;
      s_wdata  = $urandom;
      s_wstrb  = SW'($urandom);
      s_wlast  = (beat_idx == burst_len - 1);
    end
    m_tready = ($urandom % 100) < p_t;
    s_bready = ($urandom % 100) < p_b;
  endtask

  task automatic update();
    bit awf, wf, tf, bf;
    awf = s_awvalid && s_awready;
    wf  = s_wvalid && s_wready;
    tf  = m_tvalid && m_tready;
    bf  = s_bvalid && s_bready;
    if (tf && m_tlast && bf) same_cycle_b++;
    if (tf) begin
      if (m_tlast) m_owed++;
      void'(mq.pop_front());
      t_beats++;
    end
    if (wf) begin
      mq.push_back({s_wlast, s_wstrb, s_wdata});
      if (s_wlast) m_open--;
    end
    if (awf) begin m_open++; m_total++; end
    if (bf) begin m_owed--; m_total--; end
    aw_fired = awf;
    w_fired  = wf;
  endtask

  task automatic step();
    @(negedge clk);
    compare();
    drive();
    #1;
    update();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 1'b0;
    @(negedge clk);
    // R1: reset state
    chk(s_awready == 1'b1, "R1", "awready after reset", 64'(s_awready), 64'd1);
    chk(s_wready == 1'b0, "R1", "wready after reset", 64'(s_wready), 64'd0);
    chk(m_tvalid == 1'b0, "R1", "tvalid after reset", 64'(m_tvalid), 64'd0);
    chk(s_bvalid == 1'b0, "R1", "bvalid after reset", 64'(s_bvalid), 64'd0);

    // R3: data offered without any address: must not be taken
    p_aw = 0; p_w = 100; p_t = 100; p_b = 100;
    repeat (10) step();

    // random mix, short bursts make same-cycle events frequent (R8)
    p_aw = 60; p_w = 70; p_t = 60; p_b = 50;
    repeat (3000) step();

    // R6: stream stalled
    p_t = 0;
    repeat (30) step();

    // R9: responses withheld, outstanding limit reached
    p_t = 100; p_b = 0;
    repeat (60) step();
    p_b = 100;
    repeat (30) step();

    // R5: full throughput window
    p_aw = 100; p_w = 100; p_t = 100; p_b = 100;
    repeat (20) step();
    t_beats = 0;
    repeat (100) step();
    chk(t_beats == 100, "R5", "beats in 100 cycles", 64'(t_beats), 64'd100);

    p_aw = 70; p_w = 80; p_t = 70; p_b = 40;
    repeat (3000) step();
    // drain
    p_aw = 0; p_w = 100; p_t = 100; p_b = 100;
    repeat (50) step();

    chk(same_cycle_b > 0, "R8", "tlast and B in one cycle seen", 64'(same_cycle_b), 64'd1);
    chk(aw_block_seen > 0, "R2", "awready blocked with pending request", 64'(aw_block_seen), 64'd1);
    chk(m_owed == 0 && s_bvalid == 1'b0, "R8", "all responses returned", 64'(m_owed), 64'd0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule